// File: doc/BRIEF.md
# Four-Channel Memory Transfer Engine

This block copies data from one address to another over a single shared memory bus, on behalf of up to four independent channels. Each channel holds a programmed source, destination, unit count and a 16-bit control word. When the enable bit of the control word is turned on, the channel takes working copies of source, destination and count. It then waits for its start event, which is one of four: start at once, a vertical-blank pulse, a horizontal-blank pulse, or a per-channel external request.

Once running, a channel moves one unit at a time. A unit is 16 or 32 bits, read from the working source address and then written to the working destination. After each unit both addresses step according to their own mode and the count drops by one. When the count runs out, the channel either shuts itself off or re-arms for the next start event. It can raise a one-cycle interrupt on its own line. Ownership of the bus is decided again before every unit, so an urgent channel never waits for a long transfer to finish.

Configuration is one write port: a channel number, a register selector and 32 bits of data.

Top module: `xfer_dma_ctrl`

## Requirements
- R1: After reset every channel is disabled: `chan_en_o` is all zero, `bus_valid_o` is low and `irq_o` is all zero.
- R2: A control write that sets bit 15 on a channel whose enable was clear latches the working copies. With timing field bits 13:12 equal to 0, transfer starts at once. Each unit is a read of the source followed by a write of the destination. Bit 10 selects the unit: 0 is 16 bits, carried on bits 15:0 of the bus data, and 1 is 32 bits. Register selector codes are 0 source, 1 destination, 2 count, 3 control.
- R3: Control bits 6:5 set the destination mode and bits 8:7 the source mode. The codes are 0 increment, 1 decrement, 2 hold and 3 increment-with-reload. The step is 2 bytes for 16-bit units and 4 bytes for 32-bit units.
- R4: Timing code 1 waits for a pulse on `vblank_i`, code 2 waits for a pulse on `hblank_i`, and code 3 waits for the channel's own bit of `ext_req_i`. A pulse on any other trigger line moves no data.
- R5: With repeat (bit 9) set and a timing code other than 0, completion reloads the count and keeps the channel enabled, and the next trigger runs the transfer again. A mode-3 address is restored to its programmed value, while other modes carry on from where they stopped.
- R6: Without repeat, or with timing code 0, completion clears the channel's enable and no further units are moved.
- R7: If bit 14 is set, each completion gives exactly one one-cycle pulse on that channel's `irq_o` bit. If bit 14 is clear, there is no pulse.
- R8: A programmed count of zero moves 2^CNTW units (16384 with the default CNTW of 14).
- R9: Before each unit the lowest-numbered pending channel wins the bus. A lower-numbered channel that becomes pending during a long transfer finishes before that transfer does.
- R10: Clearing enable on a running channel stops it after the unit in progress. No further bus cycles are made for it.
- R11: Bus addresses have bits 1:0 cleared for 32-bit units and bit 0 cleared for 16-bit units. Address stepping wraps within the low 24 bits and leaves bits 31:24 (the region byte) unchanged.
- R12: While `bus_valid_o` is high and `bus_ready_i` is low, the address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Register selector: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data |
| vblank_i | input | 1 | Vertical-blank start pulse |
| hblank_i | input | 1 | Horizontal-blank start pulse |
| ext_req_i | input | NCH | Per-channel external start request |
| bus_valid_o | output | 1 | Bus cycle request |
| bus_write_o | output | 1 | 1 write, 0 read |
| bus_wide_o | output | 1 | 1 for 32-bit, 0 for 16-bit |
| bus_addr_o | output | 32 | Aligned bus address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data (16-bit on bits 15:0) |
| bus_ready_i | input | 1 | Bus cycle completes this clock |
| chan_en_o | output | NCH | Enable bit of each channel |
| irq_o | output | NCH | Completion interrupt pulses |

## Verification
The copy path is run in three ways. Incrementing 32-bit copies show that words move intact. Decrementing 16-bit copies show that the step direction and the halfword lane are correct. A held destination shows that only the last unit survives. Start timing is tested by pulsing the wrong trigger lines first, so a channel that starts early is caught. The two repeat variants are compared: a reloaded destination is written over, and an incrementing one keeps advancing. Arbitration is tested in two situations: several channels released by one pulse, which checks the order of writes, and a high-priority channel enabled during a long transfer, which checks preemption. A source placed at the very top of a region shows both alignment and region-confined wrap. Bus stalls show that the handshake holds.

// File: rtl/dma_pkg.sv
package dma_pkg;

   localparam int ADDR_W = 32;
   localparam int OFF_W  = 24;

   typedef enum logic [1:0] {
      STEP_INC    = 2'd0,
      STEP_DEC    = 2'd1,
      STEP_HOLD   = 2'd2,
      STEP_INC_RL = 2'd3
   } step_mode_e;

   typedef enum logic [1:0] {
      GO_NOW = 2'd0,
      GO_VBL = 2'd1,
      GO_HBL = 2'd2,
      GO_EXT = 2'd3
   } go_sel_e;

   typedef enum logic [1:0] {
      SEL_SRC  = 2'd0,
      SEL_DST  = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_CTRL = 2'd3
   } reg_sel_e;

   // step within the region offset; the region byte never changes
   function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [1:0] mode,
                                                   input logic wide);
      logic [OFF_W-1:0] off;
      logic [OFF_W-1:0] st;
      st  = wide ? OFF_W'(4) : OFF_W'(2);
      off = a[OFF_W-1:0];
      case (mode)
         STEP_INC, STEP_INC_RL: off = off + st;
         STEP_DEC:              off = off - st;
         default:               off = off;
      endcase
      return {a[ADDR_W-1:OFF_W], off};
   endfunction

   function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a,
                                                    input logic wide);
      return wide ? {a[ADDR_W-1:2], 2'b00} : {a[ADDR_W-1:1], 1'b0};
   endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
   import dma_pkg::*;
#(
   parameter int CNTW = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              vbl,
   input  logic              hbl,
   input  logic              ext_req,
   input  logic              unit_done,
   output logic              pending,
   output logic [ADDR_W-1:0] src_w,
   output logic [ADDR_W-1:0] dst_w,
   output logic              wide,
   output logic              en,
   output logic              irq
);

   localparam logic [CNTW:0] CNT_FULL = {1'b1, {CNTW{1'b0}}};
   localparam logic [CNTW:0] CNT_ONE  = {{CNTW{1'b0}}, 1'b1};

   logic [ADDR_W-1:0] src_p, dst_p;
   logic [CNTW-1:0]   cnt_p;
   logic [15:0]       ctrl_q;
   logic [CNTW:0]     cnt_w;
   logic              running;
   logic              irq_q;

   logic [1:0] dmode, smode, go;
   logic       rep, irq_en;
   logic       en_rise, en_drop, last, fire;
   logic [CNTW:0] reload;

   assign dmode  = ctrl_q[6:5];
   assign smode  = ctrl_q[8:7];
   assign rep    = ctrl_q[9];
   assign wide   = ctrl_q[10];
   assign go     = ctrl_q[13:12];
   assign irq_en = ctrl_q[14];
   assign en     = ctrl_q[15];

   assign en_rise = wr_en && (wr_sel == SEL_CTRL) && wr_data[15] && !ctrl_q[15];
   assign en_drop = wr_en && (wr_sel == SEL_CTRL) && !wr_data[15];
   assign last    = (cnt_w == CNT_ONE);
   assign reload  = (cnt_p == '0) ? CNT_FULL : {1'b0, cnt_p};

   always_comb begin
      case (go)
         GO_VBL:  fire = vbl;
         GO_HBL:  fire = hbl;
         GO_EXT:  fire = ext_req;
         default: fire = 1'b0;
      endcase
   end

   assign pending = running && en;
   assign irq     = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_p   <= '0;
         dst_p   <= '0;
         cnt_p   <= '0;
         ctrl_q  <= '0;
         src_w   <= '0;
         dst_w   <= '0;
         cnt_w   <= '0;
         running <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (wr_en) begin
            case (wr_sel)
               SEL_SRC: src_p  <= wr_data;
               SEL_DST: dst_p  <= wr_data;
               SEL_CNT: cnt_p  <= wr_data[CNTW-1:0];
               default: ctrl_q <= wr_data[15:0];
            endcase
         end
         if (en_rise) begin
            src_w   <= src_p;
            dst_w   <= dst_p;
            cnt_w   <= reload;
            running <= (wr_data[13:12] == GO_NOW);
         end else if (unit_done) begin
            src_w <= step_addr(src_w, smode, wide);
            dst_w <= step_addr(dst_w, dmode, wide);
            if (last) begin
               running <= 1'b0;
               irq_q   <= irq_en;
               if (rep && (go != GO_NOW)) begin
                  cnt_w <= reload;
                  if (dmode == STEP_INC_RL) dst_w <= dst_p;
                  if (smode == STEP_INC_RL) src_w <= src_p;
               end else begin
                  ctrl_q[15] <= 1'b0;
               end
            end else begin
               cnt_w <= cnt_w - CNT_ONE;
            end
         end else if (en && !running && fire) begin
            running <= 1'b1;
         end
         if (en_drop) running <= 1'b0;
      end
   end

   // R2: a mid-transfer unit lowers the working count by exactly one
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && !en_rise && !last) |=> (cnt_w == $past(cnt_w) - CNT_ONE));

   // R3: a held destination does not move between units
   p_hold_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && !en_rise && !last && dmode == STEP_HOLD) |=> $stable(dst_w));

   // R7: an interrupt pulse only follows a finished unit
   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(unit_done));

   // R6: one-shot completion turns the channel off
   p_oneshot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && last && !(rep && go != GO_NOW) && !wr_en) |=> !en);

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
   parameter int NCH = 4,
   localparam int CHW = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   output logic [CHW-1:0] idx,
   output logic           any
);

   always_comb begin
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) idx = CHW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/dma_eng.sv
module dma_eng
   import dma_pkg::*;
#(
   parameter int NCH = 4,
   localparam int CHW = $clog2(NCH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NCH-1:0]              pend,
   input  logic [NCH-1:0][ADDR_W-1:0]  src_all,
   input  logic [NCH-1:0][ADDR_W-1:0]  dst_all,
   input  logic [NCH-1:0]              wide_all,
   input  logic [31:0]                 bus_rdata,
   input  logic                        bus_ready,
   output logic                        bus_valid,
   output logic                        bus_write,
   output logic                        bus_wide,
   output logic [ADDR_W-1:0]           bus_addr,
   output logic [31:0]                 bus_wdata,
   output logic [NCH-1:0]              unit_done
);

   typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} eng_st_e;

   eng_st_e        st;
   logic [CHW-1:0] cur;
   logic           wide_q;
   logic [31:0]    data_q;
   logic [CHW-1:0] gidx;
   logic           gany;

   dma_arb #(.NCH(NCH)) u_arb (
      .req (pend),
      .idx (gidx),
      .any (gany)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= E_IDLE;
         cur    <= '0;
         wide_q <= 1'b0;
         data_q <= '0;
      end else begin
         case (st)
            E_IDLE: if (gany) begin
               cur    <= gidx;
               wide_q <= wide_all[gidx];
               st     <= E_RD;
            end
            E_RD: if (bus_ready) begin
               data_q <= bus_rdata;
               st     <= E_WR;
            end
            default: if (bus_ready) st <= E_IDLE;
         endcase
      end
   end

   assign bus_valid = (st != E_IDLE);
   assign bus_write = (st == E_WR);
   assign bus_wide  = wide_q;
   assign bus_addr  = align_addr(bus_write ? dst_all[cur] : src_all[cur], wide_q);
   assign bus_wdata = wide_q ? data_q : {16'h0000, data_q[15:0]};

   for (genvar i = 0; i < NCH; i++) begin : g_done
      assign unit_done[i] = (st == E_WR) && bus_ready && (cur == CHW'(i));
   end

   // R11: every bus address sits on a unit boundary
   p_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_wide ? (bus_addr[1:0] == 2'b00) : (bus_addr[0] == 1'b0)));

   // R12: a stalled cycle keeps its address, direction and data
   p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                     && $stable(bus_write) && $stable(bus_wdata)));

   // R9: the winner is a pending channel, and one unit finishes at a time
   p_grant_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gany |-> pend[gidx]);
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unit_done));

endmodule

// File: rtl/xfer_dma_ctrl.sv
module xfer_dma_ctrl
   import dma_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int CNTW = 14,
   localparam int CHW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CHW-1:0]    cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              vblank_i,
   input  logic              hblank_i,
   input  logic [NCH-1:0]    ext_req_i,
   output logic              bus_valid_o,
   output logic              bus_write_o,
   output logic              bus_wide_o,
   output logic [31:0]       bus_addr_o,
   output logic [31:0]       bus_wdata_o,
   input  logic [31:0]       bus_rdata_i,
   input  logic              bus_ready_i,
   output logic [NCH-1:0]    chan_en_o,
   output logic [NCH-1:0]    irq_o
);

   if (NCH < 2 || NCH > 8) begin : g_bad_nch
      $error("xfer_dma_ctrl: NCH must lie in 2..8");
   end
   if (CNTW < 1 || CNTW > 24) begin : g_bad_cntw
      $error("xfer_dma_ctrl: CNTW must lie in 1..24");
   end

   logic [NCH-1:0][ADDR_W-1:0] src_all, dst_all;
   logic [NCH-1:0]             wide_all, pend, done;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_chan #(.CNTW(CNTW)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && (cfg_ch == CHW'(i))),
         .wr_sel    (cfg_sel),
         .wr_data   (cfg_wdata),
         .vbl       (vblank_i),
         .hbl       (hblank_i),
         .ext_req   (ext_req_i[i]),
         .unit_done (done[i]),
         .pending   (pend[i]),
         .src_w     (src_all[i]),
         .dst_w     (dst_all[i]),
         .wide      (wide_all[i]),
         .en        (chan_en_o[i]),
         .irq       (irq_o[i])
      );
   end

   dma_eng #(.NCH(NCH)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (pend),
      .src_all   (src_all),
      .dst_all   (dst_all),
      .wide_all  (wide_all),
      .bus_rdata (bus_rdata_i),
      .bus_ready (bus_ready_i),
      .bus_valid (bus_valid_o),
      .bus_write (bus_write_o),
      .bus_wide  (bus_wide_o),
      .bus_addr  (bus_addr_o),
      .bus_wdata (bus_wdata_o),
      .unit_done (done)
   );

endmodule

// File: tb/xfer_dma_ctrl_bench.sv
`timescale 1ns/1ps
module xfer_dma_ctrl_bench;

   localparam int NCH  = 4;
   localparam int CNTW = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_ch = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        vblank_i = 1'b0, hblank_i = 1'b0;
   logic [3:0]  ext_req_i = '0;
   logic        bus_valid_o, bus_write_o, bus_wide_o;
   logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
   logic        bus_ready_i = 1'b1;
   logic [3:0]  chan_en_o, irq_o;

   int n_chk = 0, n_err = 0, cyc = 0, wr_count = 0, rd_count = 0;
   int irq_cnt [4];
   logic [31:0] wr_hist [64];
   logic [31:0] rd_hist [64];
   logic [7:0]  mem [1024];
   bit          stall = 1'b0;

   always #2.5 clk = ~clk;

   xfer_dma_ctrl u_xfer_dma_ctrl (.*);

   function automatic logic [7:0] ival(input int i);
      return 8'((i * 37 + 11) ^ (i >> 4));
   endfunction

   function automatic logic [15:0] mk(input int dm, input int sm, input bit rep, input bit wide,
                                      input int go, input bit irq, input bit en);
      return {en, irq, 2'(go), 1'b0, wide, rep, 2'(sm), 2'(dm), 5'b0};
   endfunction

   // bus memory model, 1 KiB mirrored over the whole address space
   always_comb begin
      int a;
      a = int'(bus_addr_o[9:0]);
      if (bus_wide_o)
         bus_rdata_i = {mem[(a + 3) % 1024], mem[(a + 2) % 1024], mem[(a + 1) % 1024], mem[a]};
      else
         bus_rdata_i = {16'h0000, mem[(a + 1) % 1024], mem[a]};
   end

   always @(posedge clk) begin
      if (bus_valid_o && bus_write_o && bus_ready_i) begin
         int a;
         a = int'(bus_addr_o[9:0]);
         mem[a]              <= bus_wdata_o[7:0];
         mem[(a + 1) % 1024] <= bus_wdata_o[15:8];
         if (bus_wide_o) begin
            mem[(a + 2) % 1024] <= bus_wdata_o[23:16];
            mem[(a + 3) % 1024] <= bus_wdata_o[31:24];
         end
      end
   end

   always @(negedge clk) begin
      if (bus_valid_o && bus_ready_i) begin
         if (bus_write_o) begin
            if (wr_count < 64) wr_hist[wr_count] = bus_addr_o;
            wr_count++;
         end else begin
            if (rd_count < 64) rd_hist[rd_count] = bus_addr_o;
            rd_count++;
         end
      end
      for (int i = 0; i < 4; i++) if (irq_o[i]) irq_cnt[i]++;
      if (stall) bus_ready_i = ~bus_ready_i;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 180000) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: run did not finish act=%0d exp<=%0d", cyc, 180000);
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic reset_mem();
      for (int i = 0; i < 1024; i++) mem[i] = ival(i);
   endtask

   task automatic cfg(input int ch, input int sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input int cnt, input logic [15:0] ctl);
      cfg(ch, 0, s);
      cfg(ch, 1, d);
      cfg(ch, 2, 32'(cnt));
      cfg(ch, 3, {16'h0, ctl});
   endtask

   task automatic wait_off(input int ch, input int lim, input string tag);
      int k;
      k = 0;
      while (chan_en_o[ch] && k < lim) begin @(negedge clk); k++; end
      chk(!chan_en_o[ch], tag, 32'(chan_en_o[ch]), 0);
   endtask

   task automatic wait_wr(input int n, input int lim, input string tag);
      int k;
      k = 0;
      while (wr_count < n && k < lim) begin @(negedge clk); k++; end
      chk(wr_count >= n, tag, 32'(wr_count), 32'(n));
   endtask

   task automatic pulse_v(); vblank_i = 1'b1; @(negedge clk); vblank_i = 1'b0; endtask
   task automatic pulse_h(); hblank_i = 1'b1; @(negedge clk); hblank_i = 1'b0; endtask
   task automatic pulse_x(input int ch);
      ext_req_i[ch] = 1'b1; @(negedge clk); ext_req_i[ch] = 1'b0;
   endtask

   task automatic t_reset();
      chk(chan_en_o == 4'b0, "R1 enables after reset", 32'(chan_en_o), 0);
      chk(!bus_valid_o, "R1 bus idle after reset", 32'(bus_valid_o), 0);
      chk(irq_o == 4'b0, "R1 irq after reset", 32'(irq_o), 0);
   endtask

   task automatic t_inc32();
      reset_mem();
      prog(0, 32'h0000_0040, 32'h0000_0200, 4, mk(0, 0, 0, 1, 0, 0, 1));
      wait_off(0, 100, "R2 inc32 finish");
      for (int k = 0; k < 16; k++)
         chk(mem[16'h200 + k] == ival(16'h040 + k), "R2 inc32 data", 32'(mem[16'h200 + k]), 32'(ival(16'h040 + k)));
   endtask

   task automatic t_dec16();
      reset_mem();
      prog(1, 32'h0000_007E, 32'h0000_027E, 3, mk(1, 1, 0, 0, 0, 0, 1));
      wait_off(1, 100, "R3 dec16 finish");
      for (int k = 0; k < 6; k++)
         chk(mem[16'h27A + k] == ival(16'h07A + k), "R3 dec16 data", 32'(mem[16'h27A + k]), 32'(ival(16'h07A + k)));
      chk(mem[16'h279] == ival(16'h279), "R3 dec16 below range", 32'(mem[16'h279]), 32'(ival(16'h279)));
      chk(mem[16'h280] == ival(16'h280), "R3 dec16 above range", 32'(mem[16'h280]), 32'(ival(16'h280)));
   endtask

   task automatic t_hold();
      reset_mem();
      prog(2, 32'h0000_0100, 32'h0000_0300, 3, mk(2, 0, 0, 1, 0, 0, 1));
      wait_off(2, 100, "R3 hold finish");
      for (int k = 0; k < 4; k++)
         chk(mem[16'h300 + k] == ival(16'h108 + k), "R3 held dest keeps last unit", 32'(mem[16'h300 + k]), 32'(ival(16'h108 + k)));
      chk(mem[16'h304] == ival(16'h304), "R3 held dest no spill", 32'(mem[16'h304]), 32'(ival(16'h304)));
   endtask

   task automatic t_hblank();
      int b;
      reset_mem();
      b = wr_count;
      prog(1, 32'h0000_0010, 32'h0000_0210, 2, mk(0, 0, 0, 1, 2, 0, 1));
      repeat (8) @(negedge clk);
      pulse_v();
      repeat (8) @(negedge clk);
      chk(wr_count == b, "R4 hblank channel ignores vblank", 32'(wr_count - b), 0);
      chk(chan_en_o[1], "R4 hblank channel still armed", 32'(chan_en_o[1]), 1);
      pulse_h();
      wait_off(1, 100, "R4 hblank finish");
      chk(wr_count == b + 2, "R4 hblank unit count", 32'(wr_count - b), 2);
      chk(mem[16'h214] == ival(16'h014), "R4 hblank data", 32'(mem[16'h214]), 32'(ival(16'h014)));
   endtask

   task automatic t_ext();
      int b;
      reset_mem();
      b = wr_count;
      prog(3, 32'h0000_0020, 32'h0000_0220, 2, mk(0, 0, 0, 0, 3, 0, 1));
      pulse_x(2);
      pulse_v();
      pulse_h();
      repeat (8) @(negedge clk);
      chk(wr_count == b, "R4 ext channel ignores other lines", 32'(wr_count - b), 0);
      pulse_x(3);
      wait_off(3, 100, "R4 ext finish");
      chk(mem[16'h222] == ival(16'h022), "R4 ext data", 32'(mem[16'h222]), 32'(ival(16'h022)));
   endtask

   task automatic t_rep_reload();
      int b, q;
      reset_mem();
      b = wr_count; q = irq_cnt[1];
      prog(1, 32'h0000_0000, 32'h0000_0380, 2, mk(3, 0, 1, 1, 1, 1, 1));
      pulse_v();
      wait_wr(b + 2, 100, "R5 first run");
      repeat (5) @(negedge clk);
      chk(chan_en_o[1], "R5 repeat stays enabled", 32'(chan_en_o[1]), 1);
      chk(mem[16'h384] == ival(16'h004), "R5 first run data", 32'(mem[16'h384]), 32'(ival(16'h004)));
      pulse_v();
      wait_wr(b + 4, 100, "R5 second run");
      repeat (5) @(negedge clk);
      chk(mem[16'h380] == ival(16'h008), "R5 reloaded dest rewritten", 32'(mem[16'h380]), 32'(ival(16'h008)));
      chk(mem[16'h388] == ival(16'h388), "R5 reloaded dest no advance", 32'(mem[16'h388]), 32'(ival(16'h388)));
      chk(irq_cnt[1] == q + 2, "R7 one pulse per run", 32'(irq_cnt[1] - q), 2);
      cfg(1, 3, {16'h0, mk(3, 0, 1, 1, 1, 1, 0)});
      chk(!chan_en_o[1], "R10 repeat channel disabled", 32'(chan_en_o[1]), 0);
   endtask

   task automatic t_rep_inc();
      int b;
      reset_mem();
      b = wr_count;
      prog(2, 32'h0000_0000, 32'h0000_0380, 2, mk(0, 0, 1, 1, 2, 0, 1));
      pulse_h();
      wait_wr(b + 2, 100, "R5 inc first run");
      pulse_h();
      wait_wr(b + 4, 100, "R5 inc second run");
      repeat (5) @(negedge clk);
      chk(mem[16'h388] == ival(16'h008), "R5 inc dest continues", 32'(mem[16'h388]), 32'(ival(16'h008)));
      cfg(2, 3, 32'h0);
   endtask

   task automatic t_now_rep();
      int b, q;
      b = wr_count; q = irq_cnt[0];
      prog(0, 32'h0000_0000, 32'h0000_0300, 2, mk(0, 0, 1, 0, 0, 0, 1));
      wait_off(0, 100, "R6 immediate repeat clears enable");
      repeat (20) @(negedge clk);
      chk(wr_count == b + 2, "R6 no rerun", 32'(wr_count - b), 2);
      chk(irq_cnt[0] == q, "R7 no pulse when bit 14 clear", 32'(irq_cnt[0] - q), 0);
   endtask

   task automatic t_irq();
      int q;
      q = irq_cnt[2];
      prog(2, 32'h0000_0000, 32'h0000_0300, 1, mk(0, 0, 0, 0, 0, 1, 1));
      wait_off(2, 100, "R7 irq finish");
      repeat (3) @(negedge clk);
      chk(irq_cnt[2] == q + 1, "R7 single pulse", 32'(irq_cnt[2] - q), 1);
   endtask

   task automatic t_zero();
      int b;
      b = wr_count;
      prog(2, 32'h0000_0000, 32'h0000_0300, 0, mk(2, 2, 0, 0, 0, 0, 1));
      wait_off(2, 60000, "R8 zero count finish");
      chk(wr_count - b == (1 << CNTW), "R8 zero count length", 32'(wr_count - b), 32'(1 << CNTW));
   endtask

   task automatic t_prio();
      int b;
      b = wr_count;
      prog(3, 32'h0000_0000, 32'h0000_0380, 2, mk(0, 0, 0, 0, 1, 0, 1));
      prog(1, 32'h0000_0000, 32'h0000_0340, 2, mk(0, 0, 0, 0, 1, 0, 1));
      prog(0, 32'h0000_0000, 32'h0000_0300, 2, mk(0, 0, 0, 0, 1, 0, 1));
      pulse_v();
      wait_off(3, 100, "R9 all finish");
      chk(wr_hist[b] == 32'h300, "R9 ch0 first", wr_hist[b], 32'h300);
      chk(wr_hist[b + 2] == 32'h340, "R9 ch1 second", wr_hist[b + 2], 32'h340);
      chk(wr_hist[b + 4] == 32'h380, "R9 ch3 last", wr_hist[b + 4], 32'h380);
   endtask

   task automatic t_preempt();
      int b;
      reset_mem();
      b = wr_count;
      prog(3, 32'h0000_0000, 32'h0000_0200, 20, mk(0, 0, 0, 1, 0, 0, 1));
      repeat (9) @(negedge clk);
      prog(0, 32'h0000_0300, 32'h0000_0380, 2, mk(0, 0, 0, 1, 0, 0, 1));
      wait_off(0, 100, "R9 urgent finish");
      chk(chan_en_o[3], "R9 long transfer still running", 32'(chan_en_o[3]), 1);
      wait_off(3, 200, "R9 long finish");
      chk(wr_count == b + 22, "R9 total units", 32'(wr_count - b), 22);
      chk(mem[16'h24C] == ival(16'h04C), "R9 long data intact", 32'(mem[16'h24C]), 32'(ival(16'h04C)));
   endtask

   task automatic t_abort();
      int n1;
      int b;
      b = wr_count;
      prog(1, 32'h0000_0000, 32'h0000_0200, 10, mk(0, 0, 0, 1, 0, 0, 1));
      repeat (7) @(negedge clk);
      cfg(1, 3, {16'h0, mk(0, 0, 0, 1, 0, 0, 0)});
      repeat (6) @(negedge clk);
      n1 = wr_count - b;
      chk(n1 > 0 && n1 < 10, "R10 abort partial", 32'(n1), 32'h5);
      repeat (10) @(negedge clk);
      chk(wr_count - b == n1, "R10 no more units", 32'(wr_count - b), 32'(n1));
      chk(!bus_valid_o, "R10 bus idle", 32'(bus_valid_o), 0);
   endtask

   task automatic t_region();
      int b;
      reset_mem();
      b = rd_count;
      prog(2, 32'h05FF_FFFF, 32'h0500_0200, 2, mk(0, 0, 0, 1, 0, 0, 1));
      wait_off(2, 100, "R11 finish");
      chk(rd_hist[b] == 32'h05FF_FFFC, "R11 aligned read", rd_hist[b], 32'h05FF_FFFC);
      chk(rd_hist[b + 1] == 32'h0500_0000, "R11 wrap in region", rd_hist[b + 1], 32'h0500_0000);
      chk(mem[16'h200] == ival(16'h3FC), "R11 first word", 32'(mem[16'h200]), 32'(ival(16'h3FC)));
      chk(mem[16'h205] == ival(16'h001), "R11 second word", 32'(mem[16'h205]), 32'(ival(16'h001)));
   endtask

   task automatic t_stall();
      reset_mem();
      stall = 1'b1;
      prog(0, 32'h0000_0060, 32'h0000_0260, 4, mk(0, 0, 0, 1, 0, 0, 1));
      wait_off(0, 200, "R12 stalled finish");
      stall = 1'b0;
      bus_ready_i = 1'b1;
      for (int k = 0; k < 16; k++)
         chk(mem[16'h260 + k] == ival(16'h060 + k), "R12 stalled data", 32'(mem[16'h260 + k]), 32'(ival(16'h060 + k)));
   endtask

   initial begin
      for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
      reset_mem();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_inc32();
      t_dec16();
      t_hold();
      t_hblank();
      t_ext();
      t_rep_reload();
      t_rep_inc();
      t_now_rep();
      t_irq();
      t_prio();
      t_preempt();
      t_abort();
      t_region();
      t_stall();
      t_zero();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule